// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Edge-Triggered Interrupts

The block is an eight-pin general-purpose I/O port on a simple byte-wide register bus. Every pin carries a two-bit mode field that makes it either an input watching for a falling edge, a rising edge or both edges, or a push-pull output. The fields of pins 7 to 4 sit in one control register, and those of pins 3 to 0 sit in another. A data register holds the output latch. Reading the data register returns the latch for output pins and the synchronized pin level for input pins.

Each input passes through a two-flop synchronizer. An edge is found by comparing the synchronized level with its value one cycle earlier. When a pin's interrupt enable bit is set and the edge that its mode selects occurs, a sticky pending flag is set for that pin. The shared interrupt line `irq_n` stays low while any flag is set. Software polls the pending register and clears a flag by writing zero to its bit.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, both control registers, both enable registers, the pending register and the output latch read 0x00. `pin_oe` is 0x00 and `irq_n` is 1.
- R2: Mode field encoding is 00 for falling-edge input, 01 for rising-edge input, 10 for both-edge input and 11 for push-pull output. Pin 4+k uses bits [2k+1:2k] at offset 1, and pin k uses the same bits at offset 2. `pin_oe[i]` is 1 exactly when pin i is in mode 11.
- R3: A write to offset 0 loads the output latch that drives `pin_out`, and `pin_out` changes on no other access. A read of offset 0 returns the latch bit for output pins and, for input pins, the pin level delayed by two clock edges.
- R4: In mode 00, a 1-to-0 change on an enabled pin sets its pending bit (offset 5, bit i) on the third clock edge after the change. A 0-to-1 change does nothing.
- R5: In mode 01, a 0-to-1 change on an enabled pin sets its pending bit on the third clock edge after the change. A 1-to-0 change does nothing.
- R6: In mode 10, both directions of change on an enabled pin set its pending bit.
- R7: The enables for pins 7 to 4 are in bits 3:0 at offset 3, and the enables for pins 3 to 0 are in bits 3:0 at offset 4. A pin whose enable bit is 0 never sets its pending bit, and neither does a pin in output mode.
- R8: A write to offset 5 clears every pending bit written as 0 and leaves every bit written as 1 unchanged. Pending bits never clear in any other way.
- R9: If a qualifying edge and a clearing write reach the same pending bit on the same clock edge, the bit stays set.
- R10: `irq_n` is 0 while any pending bit is 1, and 1 when all pending bits are 0.
- R11: Offsets 1 to 4 read back the values written, with bits 7:4 of offsets 3 and 4 reading 0. Offsets 6 and 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Output latch driven onto the pins |
| pin_oe | output | 8 | Per-pin output enable, high in output mode |
| irq_n | output | 1 | Shared active-low interrupt request |

## Verification
The bound checker watches several rules on every cycle. A pending bit falls only during a pending write, and only where a 0 was written. A detected edge always leaves its bit set, even against a clearing write. Output-mode pins never produce an edge hit. The output latch moves only on a data write. `irq_n` agrees with a zero pending read. Only the directed scenarios can show the three-edge latency from a pin change to its flag, the choice of edge under each mode, and the placement of mode and enable fields within their registers. They also cover the mixed data read that combines latch bits with sampled inputs.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    typedef enum logic [1:0] {
        MODE_FALL = 2'b00,
        MODE_RISE = 2'b01,
        MODE_BOTH = 2'b10,
        MODE_OUT  = 2'b11
    } pin_mode_e;

    localparam int OFS_DATA   = 0;
    localparam int OFS_CTL_HI = 1;
    localparam int OFS_CTL_LO = 2;
    localparam int OFS_EN_HI  = 3;
    localparam int OFS_EN_LO  = 4;
    localparam int OFS_PEND   = 5;

    localparam int REG_W = 8;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out,
    output logic [WIDTH-1:0] prev_out
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] sync;
        logic [WIDTH-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = raw_in;
        s_d.sync = s_q.meta;
        s_d.prev = s_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_out = s_q.sync;
    assign prev_out = s_q.prev;

endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit
    import gpio_edge_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic [N_PINS-1:0]      cur_lvl,
    input  logic [N_PINS-1:0]      old_lvl,
    input  logic [N_PINS-1:0][1:0] pin_mode,
    input  logic [N_PINS-1:0]      pin_en,
    output logic [N_PINS-1:0]      hit
);

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic rise_s, fall_s;
        assign rise_s = cur_lvl[i] & ~old_lvl[i];
        assign fall_s = ~cur_lvl[i] & old_lvl[i];

        always_comb begin
            unique case (pin_mode_e'(pin_mode[i]))
                MODE_FALL: hit[i] = pin_en[i] & fall_s;
                MODE_RISE: hit[i] = pin_en[i] & rise_s;
                MODE_BOTH: hit[i] = pin_en[i] & (rise_s | fall_s);
                default:   hit[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int N_PINS = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic              irq_n
);

    localparam int HALF  = N_PINS / 2;
    localparam int CTL_W = 2 * HALF;

    localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_CTL_HI = ADDR_W'(OFS_CTL_HI);
    localparam logic [ADDR_W-1:0] A_CTL_LO = ADDR_W'(OFS_CTL_LO);
    localparam logic [ADDR_W-1:0] A_EN_HI  = ADDR_W'(OFS_EN_HI);
    localparam logic [ADDR_W-1:0] A_EN_LO  = ADDR_W'(OFS_EN_LO);
    localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(OFS_PEND);

    typedef struct packed {
        logic [N_PINS-1:0] out;
        logic [CTL_W-1:0]  ctl_hi;
        logic [CTL_W-1:0]  ctl_lo;
        logic [HALF-1:0]   en_hi;
        logic [HALF-1:0]   en_lo;
        logic [N_PINS-1:0] pend;
    } regs_t;

    regs_t r_d, r_q;

    logic [N_PINS-1:0]      lvl_sync, lvl_prev, edge_hit, pend_q, data_view;
    logic [N_PINS-1:0][1:0] pin_mode;

    gpio_pin_sync #(.WIDTH(N_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pin_in),
        .sync_out (lvl_sync),
        .prev_out (lvl_prev)
    );

    for (genvar k = 0; k < HALF; k++) begin : g_mode
        assign pin_mode[k]      = r_q.ctl_lo[2*k +: 2];
        assign pin_mode[HALF+k] = r_q.ctl_hi[2*k +: 2];
        assign pin_oe[k]        = (pin_mode_e'(r_q.ctl_lo[2*k +: 2]) == MODE_OUT);
        assign pin_oe[HALF+k]   = (pin_mode_e'(r_q.ctl_hi[2*k +: 2]) == MODE_OUT);
    end

    gpio_edge_unit #(.N_PINS(N_PINS)) u_edge (
        .cur_lvl  (lvl_sync),
        .old_lvl  (lvl_prev),
        .pin_mode (pin_mode),
        .pin_en   ({r_q.en_hi, r_q.en_lo}),
        .hit      (edge_hit)
    );

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            case (bus_addr)
                A_DATA:   r_d.out    = bus_wdata[N_PINS-1:0];
                A_CTL_HI: r_d.ctl_hi = bus_wdata[CTL_W-1:0];
                A_CTL_LO: r_d.ctl_lo = bus_wdata[CTL_W-1:0];
                A_EN_HI:  r_d.en_hi  = bus_wdata[HALF-1:0];
                A_EN_LO:  r_d.en_lo  = bus_wdata[HALF-1:0];
                A_PEND:   r_d.pend   = r_q.pend & bus_wdata[N_PINS-1:0];
                default:  ;
            endcase
        end
        r_d.pend = r_d.pend | edge_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign data_view = (pin_oe & r_q.out) | (~pin_oe & lvl_sync);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_DATA:   bus_rdata = 8'(data_view);
            A_CTL_HI: bus_rdata = 8'(r_q.ctl_hi);
            A_CTL_LO: bus_rdata = 8'(r_q.ctl_lo);
            A_EN_HI:  bus_rdata = 8'(r_q.en_hi);
            A_EN_LO:  bus_rdata = 8'(r_q.en_lo);
            A_PEND:   bus_rdata = 8'(r_q.pend);
            default:  bus_rdata = '0;
        endcase
    end

    assign pend_q  = r_q.pend;
    assign pin_out = r_q.out;
    assign irq_n   = ~(|pend_q);

endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk #(
    parameter int N_PINS = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic [N_PINS-1:0] pin_out,
    input logic [N_PINS-1:0] pin_oe,
    input logic              irq_n,
    input logic [N_PINS-1:0] pend,
    input logic [N_PINS-1:0] hit
);

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(gpio_edge_pkg::OFS_DATA);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(gpio_edge_pkg::OFS_PEND);

    logic pend_wr;
    assign pend_wr = bus_wr && (bus_addr == A_PEND);

    // R8
    pend_no_silent_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_wr |=> (($past(pend) & ~pend) == '0));

    // R8
    pend_write_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_wr |=> ((pend & ~($past(pend & bus_wdata[N_PINS-1:0]) | $past(hit))) == '0));

    // R9
    edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((pend & $past(hit)) == $past(hit)));

    // R7
    output_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & hit) == '0);

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_DATA) |=> $stable(pin_out));

    // R10
    irq_vs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_PEND) |-> (irq_n == (bus_rdata == 8'h00)));

endmodule

bind gpio_edge_port gpio_edge_port_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_n     (irq_n),
    .pend      (pend_q),
    .hit       (edge_hit)
);

// File: tb/test_gpio_edge_port.sv
module test_gpio_edge_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pins = '0;
    logic [7:0] pin_out, pin_oe;
    logic       irq_n;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    gpio_edge_port i_gpio_edge_port (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr (bus_wr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .pin_in (pins),
        .pin_out (pin_out), .pin_oe (pin_oe), .irq_n (irq_n)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        wr(3'd3, 8'h00); wr(3'd4, 8'h00);
        wr(3'd1, 8'h00); wr(3'd2, 8'h00);
        pins = 8'h00;
        repeat (4) @(posedge clk);
        wr(3'd5, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 1; a <= 5; a++) begin
            rd(3'(a), v); chk("R1 register after reset", v, 8'h00);
        end
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_output();
        logic [7:0] v;
        wr(3'd2, 8'hC0);
        wr(3'd1, 8'h03);
        chk("R2 oe for pins 3,4", pin_oe, 8'h18);
        wr(3'd0, 8'hFF);
        chk("R3 pin_out after data write", pin_out, 8'hFF);
        rd(3'd0, v); chk("R3 mixed data read, pins low", v, 8'h18);
        @(negedge clk); pins = 8'h81;
        repeat (2) @(posedge clk);
        rd(3'd0, v); chk("R3 mixed data read, pins 0x81", v, 8'h99);
        rd(3'd5, v); chk("R7 output/disabled pins no pending", v, 8'h00);
    endtask

    task automatic t_readback();
        logic [7:0] v;
        wr(3'd1, 8'h5A); wr(3'd2, 8'hA5);
        rd(3'd1, v); chk("R11 ctl_hi readback", v, 8'h5A);
        rd(3'd2, v); chk("R11 ctl_lo readback", v, 8'hA5);
        wr(3'd3, 8'hFF); wr(3'd4, 8'hF6);
        rd(3'd3, v); chk("R11 en_hi upper bits zero", v, 8'h0F);
        rd(3'd4, v); chk("R11 en_lo upper bits zero", v, 8'h06);
        rd(3'd6, v); chk("R11 offset 6", v, 8'h00);
        rd(3'd7, v); chk("R11 offset 7", v, 8'h00);
        settle();
    endtask

    task automatic t_fall();
        logic [7:0] v;
        wr(3'd4, 8'h01);
        @(negedge clk); pins = 8'h01;
        repeat (4) @(posedge clk);
        rd(3'd5, v); chk("R4 rise ignored in fall mode", v, 8'h00);
        @(negedge clk); pins = 8'h00;
        repeat (2) @(posedge clk);
        rd(3'd5, v); chk("R4 not yet set after two edges", v, 8'h00);
        rd(3'd5, v); chk("R4 set on third edge", v, 8'h01);
        chk("R10 irq_n low", {7'd0, irq_n}, 8'h00);
        wr(3'd5, 8'h00);
        rd(3'd5, v); chk("R8 cleared by zero", v, 8'h00);
        chk("R10 irq_n high", {7'd0, irq_n}, 8'h01);
        settle();
    endtask

    task automatic t_rise();
        logic [7:0] v;
        pins = 8'h02;
        repeat (4) @(posedge clk);
        wr(3'd2, 8'h04); wr(3'd4, 8'h02);
        @(negedge clk); pins = 8'h00;
        repeat (4) @(posedge clk);
        rd(3'd5, v); chk("R5 fall ignored in rise mode", v, 8'h00);
        @(negedge clk); pins = 8'h02;
        repeat (3) @(posedge clk);
        rd(3'd5, v); chk("R5 rise sets pin1", v, 8'h02);
        settle();
    endtask

    task automatic t_both();
        logic [7:0] v;
        wr(3'd1, 8'h08); wr(3'd3, 8'h02);
        @(negedge clk); pins = 8'h20;
        repeat (3) @(posedge clk);
        rd(3'd5, v); chk("R6 rise sets pin5", v, 8'h20);
        wr(3'd5, 8'h00);
        @(negedge clk); pins = 8'h00;
        repeat (3) @(posedge clk);
        rd(3'd5, v); chk("R6 fall sets pin5", v, 8'h20);
        settle();
    endtask

    task automatic t_enable();
        logic [7:0] v;
        wr(3'd1, 8'hE0);
        wr(3'd3, 8'h08);
        @(negedge clk); pins = 8'hC0;
        repeat (4) @(posedge clk);
        @(negedge clk); pins = 8'h00;
        repeat (4) @(posedge clk);
        rd(3'd5, v); chk("R7 disabled pin6 and output pin7 quiet", v, 8'h00);
        settle();
    endtask

    task automatic t_write1();
        logic [7:0] v;
        wr(3'd2, 8'h22); wr(3'd4, 8'h05);
        @(negedge clk); pins = 8'h05;
        repeat (4) @(posedge clk);
        rd(3'd5, v); chk("R6 pins 0 and 2 pending", v, 8'h05);
        wr(3'd5, 8'hFF);
        rd(3'd5, v); chk("R8 writing ones keeps bits", v, 8'h05);
        wr(3'd5, 8'h04);
        rd(3'd5, v); chk("R8 only bit0 cleared", v, 8'h04);
        chk("R10 irq_n low with one bit", {7'd0, irq_n}, 8'h00);
        wr(3'd5, 8'h00);
        chk("R10 irq_n high when empty", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        @(negedge clk); pins = 8'h04;
        repeat (4) @(posedge clk);
        rd(3'd5, v); chk("R9 setup bit0", v, 8'h01);
        @(negedge clk); pins = 8'h00;
        repeat (2) @(posedge clk);
        @(negedge clk);
        bus_addr = 3'd5; bus_wdata = 8'h00; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(3'd5, v); chk("R9 edge wins over clear", v, 8'h04);
        settle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_output();
        t_readback();
        t_fall();
        t_rise();
        t_both();
        t_enable();
        t_write1();
        t_collide();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

endmodule